// File: doc/BRIEF.md
# Vertex Attribute Fetch Address Generator

This block turns vertex load requests into memory reads for the attributes a vertex uses, and hands the shader one complete input bundle per vertex. Requests enter a small FIFO. Each request carries a mode bit and a vertex index. The block pops the request and prepares one start address per enabled attribute in a single setup cycle. It then sends one read per enabled attribute through a single memory port. When every read has returned, it presents the bundle.

Each attribute slot holds its own configuration, written through a simple write strobe: an enable bit, a base address and a per-vertex stride. In index mode the address of attribute `a` is `base[a] + index * stride[a]`. In stream mode each attribute walks a running address that starts at its base and advances by its stride once per stream vertex. Memory responses carry the attribute number as a tag, so the memory side may return them in any order.

Top module: `vtx_attr_fetch`

## Requirements
- R1: Vertex requests are accepted whenever `vtx_ready` is high and are served in arrival order. The FIFO holds QDEPTH entries, one more vertex can be in flight, and `vtx_ready` is low while the FIFO is full.
- R2: For a vertex with `vtx_index_mode`=1, the read address for attribute `a` is `base[a] + vtx_index * stride[a]`, taken modulo 2^AW.
- R3: For a vertex with `vtx_index_mode`=0, attribute `a` reads its running address, and the running address then grows by `stride[a]`. Index-mode vertices leave the running address unchanged.
- R4: Each vertex produces exactly one memory read per enabled attribute. The reads go out in ascending attribute number, disabled attributes are skipped, and `mem_req_tag` carries the attribute number.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address and tag stay unchanged.
- R6: A response with tag `t` fills bits `[t*DW +: DW]` of `out_data`, whatever order the responses arrive in. Slots of disabled attributes read as zero.
- R7: `out_valid` rises only after every enabled attribute of the vertex has been returned. `out_mask` bit `a` is 1 exactly when attribute `a` was enabled at setup. No memory request is raised while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, the bundle and the mask stay unchanged. The next vertex is not started until the bundle is taken.
- R9: A vertex with no enabled attribute makes no memory request and is issued with `out_mask`=0.
- R10: After reset, `vtx_ready`=1, `mem_req_valid`=0 and `out_valid`=0, and every attribute is disabled with zero base and stride.
- R11: A pulse on `cfg_we` writes the enable, base and stride of attribute `cfg_attr`, and sets that attribute's running address to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_attr | input | $clog2(NUM_ATTR) | Attribute slot written |
| cfg_en | input | 1 | Enable for the slot |
| cfg_base | input | AW | Base address for the slot |
| cfg_stride | input | AW | Per-vertex stride for the slot |
| vtx_valid | input | 1 | Vertex request valid |
| vtx_ready | output | 1 | Request FIFO can accept |
| vtx_index_mode | input | 1 | 1 = index addressing, 0 = stream addressing |
| vtx_index | input | IW | Vertex index (index mode) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read address |
| mem_req_tag | output | $clog2(NUM_ATTR) | Attribute number of the read |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_tag | input | $clog2(NUM_ATTR) | Attribute number of the response |
| mem_rsp_data | input | DW | Returned data word |
| out_valid | output | 1 | Bundle valid to the shader |
| out_ready | input | 1 | Shader takes the bundle |
| out_mask | output | NUM_ATTR | Enabled attributes of the bundle |
| out_data | output | NUM_ATTR*DW | Bundle, slot `a` at `[a*DW +: DW]` |

## Verification
The bench returns responses in shuffled order after random delays. A design that wrote responses into slots by arrival order would put words in the wrong slots, and one that issued early would present a bundle with a missing word. Directed cases cover these settings: only attribute 0 enabled, only attribute 15 enabled, all sixteen enabled, zero stride, no attribute enabled, and an index times stride product that wraps. They catch an off-by-one in the skip logic, a hang or a spurious read when the enable set is empty, and a multiply truncated to the index width. Stream vertices mixed with index vertices, plus a base rewrite between bursts, expose a running address that moves on index vertices or keeps its old value after a rewrite. A phase with memory and shader both stalled fills the FIFO and checks the point where `vtx_ready` drops. A wrong depth would let the bench push one vertex too many or too few.

// File: rtl/vaf_pkg.sv
package vaf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_DRAIN,
        ST_ISSUE
    } vaf_state_e;

endpackage

// File: rtl/vaf_req_queue.sv
module vaf_req_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic push, pop;

    assign in_ready  = (q.cnt != CW'(DEPTH));
    assign out_valid = (q.cnt != '0);
    assign out_data  = q.slot[q.rd];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_comb begin
        d = q;
        if (push) begin
            d.slot[q.wr] = in_data;
            d.wr         = bump(q.wr);
        end
        if (pop) begin
            d.rd = bump(q.rd);
        end
        if (push && !pop) begin
            d.cnt = q.cnt + 1'b1;
        end else if (pop && !push) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/vaf_addr_gen.sv
module vaf_addr_gen #(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_en,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_stride,
    input  logic          setup,
    input  logic          index_mode,
    input  logic [IW-1:0] index,
    output logic          en,
    output logic [AW-1:0] cur_addr
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
        logic [AW-1:0] stride;
        logic [AW-1:0] run;
        logic [AW-1:0] cur;
    } gen_t;

    gen_t q, d;

    logic [AW-1:0] idx_ext;
    logic [AW-1:0] idx_addr;

    assign idx_ext  = AW'(index);
    assign idx_addr = q.base + idx_ext * q.stride;
    assign en       = q.en;
    assign cur_addr = q.cur;

    always_comb begin
        d = q;
        if (setup) begin
            if (index_mode) begin
                d.cur = idx_addr;
            end else begin
                d.cur = q.run;
                d.run = q.run + q.stride;
            end
        end
        if (cfg_we) begin
            d.en     = cfg_en;
            d.base   = cfg_base;
            d.stride = cfg_stride;
            d.run    = cfg_base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/vaf_pick.sv
module vaf_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         pend,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int TW = $clog2(N);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = TW'(i);
            end
        end
    end

endmodule

// File: rtl/vaf_collect.sv
module vaf_collect #(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 rsp_valid,
    input  logic [$clog2(N)-1:0] rsp_tag,
    input  logic [DW-1:0]        rsp_data,
    output logic [N-1:0]         got,
    output logic [N*DW-1:0]      data
);
    typedef struct packed {
        logic [N-1:0]          got;
        logic [N-1:0][DW-1:0]  word;
    } col_t;

    col_t q, d;

    assign got  = q.got;
    assign data = q.word;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (rsp_valid) begin
            d.got[rsp_tag]  = 1'b1;
            d.word[rsp_tag] = rsp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/vtx_attr_fetch.sv
module vtx_attr_fetch #(
    parameter int NUM_ATTR = 16,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IW       = 16,
    parameter int QDEPTH   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [$clog2(NUM_ATTR)-1:0] cfg_attr,
    input  logic                        cfg_en,
    input  logic [AW-1:0]               cfg_base,
    input  logic [AW-1:0]               cfg_stride,
    input  logic                        vtx_valid,
    output logic                        vtx_ready,
    input  logic                        vtx_index_mode,
    input  logic [IW-1:0]               vtx_index,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [AW-1:0]               mem_req_addr,
    output logic [$clog2(NUM_ATTR)-1:0] mem_req_tag,
    input  logic                        mem_rsp_valid,
    input  logic [$clog2(NUM_ATTR)-1:0] mem_rsp_tag,
    input  logic [DW-1:0]               mem_rsp_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NUM_ATTR-1:0]         out_mask,
    output logic [NUM_ATTR*DW-1:0]      out_data
);
    import vaf_pkg::*;

    localparam int TW = $clog2(NUM_ATTR);
    localparam int QW = IW + 1;

    typedef struct packed {
        vaf_state_e          st;
        logic                mode;
        logic [IW-1:0]       idx;
        logic [NUM_ATTR-1:0] en_mask;
        logic [NUM_ATTR-1:0] pend;
    } ctl_t;

    ctl_t q, d;

    logic                qo_valid;
    logic                qo_pop;
    logic [QW-1:0]       qo_data;
    logic                setup;
    logic                pick_any;
    logic [TW-1:0]       pick_idx;
    logic [NUM_ATTR-1:0] gen_en;
    logic [NUM_ATTR-1:0] got;
    logic [AW-1:0]       cur_addr [NUM_ATTR];

    vaf_req_queue #(
        .DEPTH (QDEPTH),
        .W     (QW)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (vtx_valid),
        .in_ready  (vtx_ready),
        .in_data   ({vtx_index_mode, vtx_index}),
        .out_valid (qo_valid),
        .out_ready (qo_pop),
        .out_data  (qo_data)
    );

    for (genvar a = 0; a < NUM_ATTR; a++) begin : g_gen
        vaf_addr_gen #(
            .AW (AW),
            .IW (IW)
        ) u_gen (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_attr == TW'(a))),
            .cfg_en     (cfg_en),
            .cfg_base   (cfg_base),
            .cfg_stride (cfg_stride),
            .setup      (setup),
            .index_mode (q.mode),
            .index      (q.idx),
            .en         (gen_en[a]),
            .cur_addr   (cur_addr[a])
        );
    end

    vaf_pick #(
        .N (NUM_ATTR)
    ) u_pick (
        .pend (q.pend),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    vaf_collect #(
        .N  (NUM_ATTR),
        .DW (DW)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (setup),
        .rsp_valid (mem_rsp_valid),
        .rsp_tag   (mem_rsp_tag),
        .rsp_data  (mem_rsp_data),
        .got       (got),
        .data      (out_data)
    );

    assign qo_pop       = (q.st == ST_IDLE);
    assign mem_req_addr = cur_addr[pick_idx];
    assign mem_req_tag  = pick_idx;
    assign out_valid    = (q.st == ST_ISSUE);
    assign out_mask     = q.en_mask;

    always_comb begin
        d             = q;
        setup         = 1'b0;
        mem_req_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (qo_valid) begin
                    d.mode = qo_data[IW];
                    d.idx  = qo_data[IW-1:0];
                    d.st   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                setup     = 1'b1;
                d.en_mask = gen_en;
                d.pend    = gen_en;
                d.st      = ST_LOAD;
            end
            ST_LOAD: begin
                if (pick_any) begin
                    mem_req_valid = 1'b1;
                    if (mem_req_ready) begin
                        d.pend[pick_idx] = 1'b0;
                    end
                end else begin
                    d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if ((got & q.en_mask) == q.en_mask) begin
                    d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (out_ready) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/vaf_checker.sv
module vaf_checker #(
    parameter int NUM_ATTR = 16,
    parameter int AW       = 32,
    parameter int DW       = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        mem_req_valid,
    input logic                        mem_req_ready,
    input logic [AW-1:0]               mem_req_addr,
    input logic [$clog2(NUM_ATTR)-1:0] mem_req_tag,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [NUM_ATTR-1:0]         out_mask,
    input logic [NUM_ATTR*DW-1:0]      out_data
);
    logic zero_ok;

    always_comb begin
        zero_ok = 1'b1;
        for (int a = 0; a < NUM_ATTR; a++) begin
            if (!out_mask[a] && (out_data[a*DW +: DW] != '0)) begin
                zero_ok = 1'b0;
            end
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag));

    p_tag_rising_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=>
            !mem_req_valid || (mem_req_tag > $past(mem_req_tag)));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=>
            out_valid && $stable(out_data) && $stable(out_mask));

    p_no_req_in_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req_valid);

    p_disabled_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> zero_ok);

endmodule

bind vtx_attr_fetch vaf_checker #(
    .NUM_ATTR (NUM_ATTR),
    .AW       (AW),
    .DW       (DW)
) u_vaf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_tag   (mem_req_tag),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_mask      (out_mask),
    .out_data      (out_data)
);

// File: tb/vtx_attr_fetch_bench.sv
`timescale 1ns/1ps
module vtx_attr_fetch_bench;
    localparam int NA = 16;
    localparam int QD = 4;
    localparam int MAXV = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_attr = '0;
    logic        cfg_en = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_stride = '0;
    logic        vtx_valid = 1'b0;
    logic        vtx_ready;
    logic        vtx_index_mode = 1'b0;
    logic [15:0] vtx_index = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [3:0]  mem_req_tag;
    logic        mem_rsp_valid = 1'b0;
    logic [3:0]  mem_rsp_tag = '0;
    logic [31:0] mem_rsp_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_mask;
    logic [NA*32-1:0] out_data;

    vtx_attr_fetch u_vtx_attr_fetch (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_attr(cfg_attr), .cfg_en(cfg_en),
        .cfg_base(cfg_base), .cfg_stride(cfg_stride),
        .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
        .vtx_index_mode(vtx_index_mode), .vtx_index(vtx_index),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_mask(out_mask), .out_data(out_data)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails = 0;

    logic        m_en     [NA];
    logic [31:0] m_base   [NA];
    logic [31:0] m_stride [NA];
    logic [31:0] m_run    [NA];

    logic [15:0] e_mask [MAXV];
    logic [31:0] e_addr [MAXV][NA];
    int push_cnt = 0;
    int done_cnt = 0;
    logic [15:0] seen = '0;

    logic [3:0]  p_tag  [16];
    logic [31:0] p_data [16];
    int p_n = 0;

    int pr_mem = 70, pr_out = 70, pr_rsp = 50;
    bit mon_on = 1'b0;

    logic        prev_mem_stall = 1'b0;
    logic [31:0] sv_addr;
    logic [3:0]  sv_tag;
    logic        prev_out_stall = 1'b0;
    logic [NA*32-1:0] sv_data;
    logic [15:0] sv_mask;

    function automatic logic [31:0] word_of(input logic [31:0] addr, input logic [3:0] tag);
        return addr ^ (32'(tag) * 32'h0101_0101) ^ 32'h5A3C_0000;
    endfunction

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic cfg_write(input int a, input logic en, input logic [31:0] base,
                             input logic [31:0] stride);
        @(negedge clk);
        cfg_we = 1'b1; cfg_attr = 4'(a); cfg_en = en; cfg_base = base; cfg_stride = stride;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[a] = en; m_base[a] = base; m_stride[a] = stride; m_run[a] = base;
    endtask

    task automatic record_vtx(input logic mode, input logic [15:0] idx);
        for (int a = 0; a < NA; a++) begin
            e_mask[push_cnt][a] = m_en[a];
            if (mode) begin
                e_addr[push_cnt][a] = m_base[a] + 32'(idx) * m_stride[a];
            end else begin
                e_addr[push_cnt][a] = m_run[a];
                m_run[a] = m_run[a] + m_stride[a];
            end
        end
        push_cnt++;
    endtask

    task automatic push_vtx(input logic mode, input logic [15:0] idx);
        @(negedge clk);
        vtx_valid = 1'b1; vtx_index_mode = mode; vtx_index = idx;
        while (!vtx_ready) @(negedge clk);
        record_vtx(mode, idx);
        @(negedge clk);
        vtx_valid = 1'b0;
    endtask

    task automatic drain();
        while (done_cnt != push_cnt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic rand_cfg();
        for (int a = 0; a < NA; a++) begin
            cfg_write(a, 1'($urandom % 2), $urandom & 32'hFFFF_FFF0,
                      ($urandom % 4 == 0) ? $urandom : 32'($urandom % 256));
        end
    endtask

    task automatic rand_vertices(input int n);
        for (int i = 0; i < n; i++) begin
            push_vtx(1'($urandom % 2), 16'($urandom));
        end
    endtask

    // Memory model, shader model and output checks.
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_mem_stall) begin
                check("R5 request held", {mem_req_valid, sv_addr, sv_tag},
                      {1'b1, mem_req_addr, mem_req_tag});
            end
            if (prev_out_stall) begin
                check("R8 bundle held", {out_valid, 47'(out_mask)}, {1'b1, 47'(sv_mask)});
                check("R8 bundle data held", 64'(out_data == sv_data), 64'd1);
            end
            if (out_valid) begin
                check("R7 all returned before issue", {31'(p_n), 1'b0, 16'(seen)},
                      {32'd0, 16'(e_mask[done_cnt])});
            end
            mem_rsp_valid = 1'b0;
            if (p_n > 0 && ($urandom % 100) < pr_rsp) begin
                int k;
                k = int'($urandom % p_n);
                mem_rsp_valid = 1'b1;
                mem_rsp_tag = p_tag[k];
                mem_rsp_data = p_data[k];
                p_tag[k] = p_tag[p_n-1];
                p_data[k] = p_data[p_n-1];
                p_n--;
            end
            mem_req_ready = (($urandom % 100) < pr_mem);
            if (mem_req_valid && mem_req_ready) begin
                logic [15:0] left;
                int exp_tag;
                left = e_mask[done_cnt] & ~seen;
                exp_tag = -1;
                for (int a = NA - 1; a >= 0; a--) if (left[a]) exp_tag = a;
                check("R4 attribute order and tag", 64'(mem_req_tag), 64'(exp_tag));
                if (exp_tag >= 0) begin
                    check("R2 index-mode or R3 R11 stream-mode address",
                          64'(mem_req_addr), 64'(e_addr[done_cnt][exp_tag]));
                end
                seen[mem_req_tag] = 1'b1;
                p_tag[p_n] = mem_req_tag;
                p_data[p_n] = word_of(mem_req_addr, mem_req_tag);
                p_n++;
            end
            prev_mem_stall = mem_req_valid && !mem_req_ready;
            sv_addr = mem_req_addr;
            sv_tag = mem_req_tag;
            out_ready = (($urandom % 100) < pr_out);
            if (out_valid && out_ready) begin
                check("R7 R9 R10 issue mask", 64'(out_mask), 64'(e_mask[done_cnt]));
                for (int a = 0; a < NA; a++) begin
                    check("R6 slot data", 64'(out_data[a*32 +: 32]),
                          e_mask[done_cnt][a] ? 64'(word_of(e_addr[done_cnt][a], 4'(a))) : 64'd0);
                end
                done_cnt++;
                seen = '0;
            end
            prev_out_stall = out_valid && !out_ready;
            sv_data = out_data;
            sv_mask = out_mask;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        int acc;
        void'($urandom(32'd20240611));
        for (int a = 0; a < NA; a++) begin
            m_en[a] = 1'b0; m_base[a] = '0; m_stride[a] = '0; m_run[a] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        check("R10 vtx_ready after reset", 64'(vtx_ready), 64'd1);
        check("R10 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        check("R10 out_valid after reset", 64'(out_valid), 64'd0);
        mon_on = 1'b1;

        // R9 R10: nothing enabled after reset -> empty bundle, no read
        push_vtx(1'b1, 16'd7);
        push_vtx(1'b0, 16'd0);
        drain();

        // Random configurations and mixed vertex streams (R2 R3 R4 R6 R11)
        for (int r = 0; r < 8; r++) begin
            rand_cfg();
            rand_vertices(30);
            drain();
        end

        // Directed: only attribute 0, only attribute 15, all sixteen
        for (int a = 0; a < NA; a++) cfg_write(a, a == 0, 32'h1000 + 32'(a) * 32'h100, 32'd16);
        rand_vertices(4);
        drain();
        for (int a = 0; a < NA; a++) cfg_write(a, a == 15, 32'h2000, 32'd8);
        rand_vertices(4);
        drain();
        for (int a = 0; a < NA; a++) cfg_write(a, 1'b1, 32'(a) * 32'h40, 32'(a) * 32'd4);
        rand_vertices(6);
        drain();
        // zero stride, and an index * stride product that wraps (R2)
        cfg_write(3, 1'b1, 32'hDEAD_0000, 32'd0);
        cfg_write(4, 1'b1, 32'hF000_0000, 32'h0010_0001);
        push_vtx(1'b1, 16'hFFFF);
        push_vtx(1'b0, 16'h0);
        push_vtx(1'b0, 16'h0);
        drain();
        // R11: rewriting a base restarts the stream walk
        cfg_write(5, 1'b1, 32'h0000_8000, 32'd32);
        push_vtx(1'b0, 16'h0);
        push_vtx(1'b0, 16'h0);
        drain();
        // R9: none enabled mid-run
        for (int a = 0; a < NA; a++) cfg_write(a, 1'b0, 32'h0, 32'h0);
        rand_vertices(3);
        drain();

        // R1: stall memory and shader, fill the FIFO
        cfg_write(2, 1'b1, 32'h4000, 32'd4);
        pr_mem = 0; pr_out = 0;
        acc = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            vtx_valid = 1'b1; vtx_index_mode = 1'b1; vtx_index = 16'(i + 1);
            if (vtx_ready) begin
                record_vtx(1'b1, 16'(i + 1));
                acc++;
            end
        end
        @(negedge clk);
        vtx_valid = 1'b0;
        check("R1 vertices accepted while stalled", 64'(acc), 64'(QD + 1));
        check("R1 vtx_ready low when full", 64'(vtx_ready), 64'd0);
        pr_mem = 60; pr_out = 60;
        drain();
        check("R1 all vertices issued in order", 64'(done_cnt), 64'(push_cnt));

        finish_run();
    end

endmodule